// File: doc/BRIEF.md
# Variable-Latency Pipeline Interlock Controller

This block is the control core of an in-order pipeline with five steps: fetch, decode, operand read, execute and write-back. It does not move data. It tracks the instructions in flight and decides each cycle which step may advance and which must hold. Each instruction arrives as an operation class, one destination register and two source registers. The execute step is not a single slot but a small pool. Independent long operations can be in execute at the same time, and each one counts down its own latency. An instruction that reads a register still being produced is held in decode until its producer is in its final execute cycle. It then enters operand read in the next cycle, so the result can be forwarded.

Instructions come in on a valid/ready port. An instruction is taken on a rising edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the sender keeps `in_valid` and the instruction fields unchanged. The block shows per-step occupancy, per-step stall flags, a dependency-hold flag and the number of busy execute slots. It gives a one-cycle retire pulse, in program order, carrying the destination and class of the retiring instruction.

Top module: `pipe_interlock`

## Requirements
- R1: A synchronous active-high reset empties every step and the execute pool. In the cycle after reset `occ_o` is 0, `ex_count_o` is 0, `retire_o` is low and `in_ready` is high. An instruction in flight when reset is applied never retires.
- R2: An instruction is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the fetch step holds an instruction that cannot move on to decode.
- R3: Fetch, decode, operand read and write-back each take exactly one cycle when nothing blocks them. Counting the cycle an instruction first occupies fetch as cycle 1, an unblocked instruction retires in cycle 4 + L, where L is its execute latency.
- R4: The execute latency L is set by `in_op`: 2'd0 add is 1, 2'd1 subtract is 1, 2'd2 multiply is 3 and 2'd3 divide is 6 (all defaults).
- R5: When either source of the instruction in decode equals the destination of an older instruction, decode holds and `hold_o` is high. The older instruction is one that is in operand read, or in execute with more than one cycle left. The consumer enters operand read in the cycle after the producer's last execute cycle.
- R6: Register 0 never creates a dependency.
- R7: Independent instructions may be in execute together. A multiply followed by an independent divide retire in cycles 7 and 11.
- R8: Retirement is in program order, one per cycle. An instruction that finishes execute behind an older, longer one waits in the pool. `retire_rd_o` carries the destination of the retiring instruction.
- R9: A stalled step keeps its instruction, and every younger step behind it stalls too. `stall_o` bit 0 is fetch, bit 1 is decode and bit 2 is operand read.
- R10: The pool holds at most EX_SLOTS instructions (default 4). When it is full and its oldest entry is not leaving, operand read stalls.
- R11: The sequence multiply r2,r10,r1; divide r5,r3,r4; add r2,r5,r2; subtract r5,r2,r6 retires in cycles 7, 11, 13 and 15, with destinations 2, 5, 2, 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Fetch step can take an instruction |
| in_op | input | 2 | Operation class (see R4) |
| in_rd | input | REG_W | Destination register |
| in_rs1 | input | REG_W | First source register |
| in_rs2 | input | REG_W | Second source register |
| occ_o | output | 5 | Occupancy: bit0 fetch, bit1 decode, bit2 operand read, bit3 execute, bit4 write-back |
| ex_count_o | output | clog2(EX_SLOTS+1) | Busy execute slots |
| stall_o | output | 3 | Stall flags: fetch, decode, operand read |
| hold_o | output | 1 | Decode held by a dependency |
| retire_o | output | 1 | One-cycle retire pulse |
| retire_rd_o | output | REG_W | Destination of the retiring instruction |
| retire_op_o | output | 2 | Class of the retiring instruction |

## Verification
A corrupted remaining-cycle count in the pool shows up as a retire pulse that comes early or late. That is visible within at most six cycles of the instruction entering execute, and every younger retire after it shifts too. A wrong match in the dependency compare moves the consumer's retire by a whole producer latency. Alternatively, it raises `hold_o` in a cycle where the directed sequence expects it low. A lost valid bit or a broken stall chain appears at once in `occ_o` and `stall_o`, or as a missing or doubled retire pulse.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_MUL = 2'd2,
    OPC_DIV = 2'd3
  } opc_e;

  localparam int STG_IF  = 0;
  localparam int STG_ID  = 1;
  localparam int STG_OF  = 2;
  localparam int STG_EX  = 3;
  localparam int STG_WO  = 4;
  localparam int NUM_STG = 5;
endpackage

// File: rtl/pi_stage_reg.sv
module pi_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  logic         v_q;
  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load_i) begin
      v_q <= 1'b1;
    end else if (adv_i) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) q_q <= d_i;
  end

  assign valid_o = v_q;
  assign q_o     = q_q;

  // R9: a held step keeps its contents
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (v_q && !adv_i) |=> (v_q && q_q == $past(q_q)));
endmodule

// File: rtl/pi_hazard.sv
module pi_hazard #(
  parameter int SLOTS = 4,
  parameter int REG_W = 5
) (
  input  logic                        id_valid_i,
  input  logic [REG_W-1:0]            rs1_i,
  input  logic [REG_W-1:0]            rs2_i,
  input  logic                        of_valid_i,
  input  logic [REG_W-1:0]            of_rd_i,
  input  logic [SLOTS-1:0]            pend_v_i,
  input  logic [SLOTS-1:0][REG_W-1:0] pend_rd_i,
  output logic                        hold_o
);
  logic [SLOTS-1:0] hit1, hit2;
  logic dep1, dep2;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit1[g] = pend_v_i[g] && (pend_rd_i[g] == rs1_i);
    assign hit2[g] = pend_v_i[g] && (pend_rd_i[g] == rs2_i);
  end

  // R6: register 0 is never a producer
  assign dep1 = (rs1_i != '0) && ((|hit1) || (of_valid_i && of_rd_i == rs1_i));
  assign dep2 = (rs2_i != '0) && ((|hit2) || (of_valid_i && of_rd_i == rs2_i));
  assign hold_o = id_valid_i && (dep1 || dep2);
endmodule

// File: rtl/pi_exec_pool.sv
module pi_exec_pool #(
  parameter int SLOTS = 4,
  parameter int REG_W = 5,
  parameter int LAT_W = 3,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push_i,
  input  logic [REG_W-1:0]            push_rd_i,
  input  logic [1:0]                  push_op_i,
  input  logic [LAT_W-1:0]            push_lat_i,
  output logic                        can_push_o,
  output logic                        pop_o,
  output logic [REG_W-1:0]            pop_rd_o,
  output logic [1:0]                  pop_op_o,
  output logic [CW-1:0]               count_o,
  output logic [SLOTS-1:0]            pend_v_o,
  output logic [SLOTS-1:0][REG_W-1:0] pend_rd_o
);
  logic             v_q   [SLOTS];
  logic [REG_W-1:0] rd_q  [SLOTS];
  logic [1:0]       op_q  [SLOTS];
  logic [LAT_W-1:0] rem_q [SLOTS];

  logic             ev   [SLOTS+1];
  logic [REG_W-1:0] erd  [SLOTS+1];
  logic [1:0]       eop  [SLOTS+1];
  logic [LAT_W-1:0] erem [SLOTS+1];

  logic             nv   [SLOTS];
  logic [REG_W-1:0] nrd  [SLOTS];
  logic [1:0]       nop  [SLOTS];
  logic [LAT_W-1:0] nrem [SLOTS];

  logic [CW-1:0] cnt_q, tail;
  logic          push_ok;

  // Oldest entry sits in slot 0; it leaves once in (or past) its last cycle.
  assign pop_o      = v_q[0] && (rem_q[0] <= LAT_W'(1));
  assign pop_rd_o   = rd_q[0];
  assign pop_op_o   = op_q[0];
  assign can_push_o = (cnt_q < CW'(SLOTS)) || pop_o;
  assign push_ok    = push_i && can_push_o;
  assign tail       = cnt_q - CW'(pop_o);
  assign count_o    = cnt_q;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      ev[i]   = v_q[i];
      erd[i]  = rd_q[i];
      eop[i]  = op_q[i];
      erem[i] = rem_q[i];
    end
    ev[SLOTS]   = 1'b0;
    erd[SLOTS]  = '0;
    eop[SLOTS]  = '0;
    erem[SLOTS] = '0;
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      int src;
      src     = pop_o ? i + 1 : i;
      nv[i]   = ev[src];
      nrd[i]  = erd[src];
      nop[i]  = eop[src];
      nrem[i] = (erem[src] != '0) ? erem[src] - LAT_W'(1) : erem[src];
      if (push_ok && tail == CW'(i)) begin
        nv[i]   = 1'b1;
        nrd[i]  = push_rd_i;
        nop[i]  = push_op_i;
        nrem[i] = push_lat_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) v_q[i] <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_o);
      for (int i = 0; i < SLOTS; i++) v_q[i] <= nv[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      rd_q[i]  <= nrd[i];
      op_q[i]  <= nop[i];
      rem_q[i] <= nrem[i];
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_pend
    assign pend_v_o[g]  = v_q[g] && (rem_q[g] > LAT_W'(1));
    assign pend_rd_o[g] = rd_q[g];
  end

  // R10: pool never holds more than its capacity
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SLOTS));
  // R4: every accepted entry carries a non-zero latency
  p_lat_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    push_ok |-> (push_lat_i != '0));
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pi_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int EX_SLOTS = 4,
  parameter int LAT_ADD  = 1,
  parameter int LAT_SUB  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [1:0]                     in_op,
  input  logic [REG_W-1:0]               in_rd,
  input  logic [REG_W-1:0]               in_rs1,
  input  logic [REG_W-1:0]               in_rs2,
  output logic [NUM_STG-1:0]             occ_o,
  output logic [$clog2(EX_SLOTS+1)-1:0]  ex_count_o,
  output logic [2:0]                     stall_o,
  output logic                           hold_o,
  output logic                           retire_o,
  output logic [REG_W-1:0]               retire_rd_o,
  output logic [1:0]                     retire_op_o
);
  localparam int MAX_A   = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
  localparam int MAX_B   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int LW      = $clog2(MAX_LAT + 1);
  localparam int CW      = $clog2(EX_SLOTS + 1);
  localparam int FW      = 2 + 3 * REG_W;
  localparam int WW      = 2 + REG_W;

  logic          if_v, id_v, of_v, wo_v;
  logic [FW-1:0] if_q, id_q, of_q;
  logic [WW-1:0] wo_q;
  logic          if_adv, id_adv, of_adv;
  logic          if_free, id_free, of_free;
  logic          in_fire, hold;

  logic [REG_W-1:0] id_rs1, id_rs2, of_rd;
  logic [1:0]       of_op;
  logic [LW-1:0]    of_lat;

  logic                           can_push, pop;
  logic [REG_W-1:0]               pop_rd;
  logic [1:0]                     pop_op;
  logic [CW-1:0]                  ex_cnt;
  logic [EX_SLOTS-1:0]            pend_v;
  logic [EX_SLOTS-1:0][REG_W-1:0] pend_rd;

  assign id_rs1 = id_q[2*REG_W-1:REG_W];
  assign id_rs2 = id_q[REG_W-1:0];
  assign of_rd  = of_q[3*REG_W-1:2*REG_W];
  assign of_op  = of_q[FW-1:FW-2];

  // Advance chain, resolved from write-back backwards.
  assign of_adv  = of_v && can_push;
  assign of_free = !of_v || of_adv;
  assign id_adv  = id_v && !hold && of_free;
  assign id_free = !id_v || id_adv;
  assign if_adv  = if_v && id_free;
  assign if_free = !if_v || if_adv;
  assign in_ready = if_free;
  assign in_fire  = in_valid && in_ready;

  pi_stage_reg #(.W(FW)) u_if (
    .clk(clk), .rst(rst), .load_i(in_fire), .adv_i(if_adv),
    .d_i({in_op, in_rd, in_rs1, in_rs2}), .valid_o(if_v), .q_o(if_q));

  pi_stage_reg #(.W(FW)) u_id (
    .clk(clk), .rst(rst), .load_i(if_adv), .adv_i(id_adv),
    .d_i(if_q), .valid_o(id_v), .q_o(id_q));

  pi_stage_reg #(.W(FW)) u_of (
    .clk(clk), .rst(rst), .load_i(id_adv), .adv_i(of_adv),
    .d_i(id_q), .valid_o(of_v), .q_o(of_q));

  pi_stage_reg #(.W(WW)) u_wo (
    .clk(clk), .rst(rst), .load_i(pop), .adv_i(1'b1),
    .d_i({pop_op, pop_rd}), .valid_o(wo_v), .q_o(wo_q));

  pi_hazard #(.SLOTS(EX_SLOTS), .REG_W(REG_W)) u_haz (
    .id_valid_i(id_v), .rs1_i(id_rs1), .rs2_i(id_rs2),
    .of_valid_i(of_v), .of_rd_i(of_rd),
    .pend_v_i(pend_v), .pend_rd_i(pend_rd), .hold_o(hold));

  always_comb begin
    case (of_op)
      OPC_ADD: of_lat = LW'(LAT_ADD);
      OPC_SUB: of_lat = LW'(LAT_SUB);
      OPC_MUL: of_lat = LW'(LAT_MUL);
      default: of_lat = LW'(LAT_DIV);
    endcase
  end

  pi_exec_pool #(.SLOTS(EX_SLOTS), .REG_W(REG_W), .LAT_W(LW), .CW(CW)) u_pool (
    .clk(clk), .rst(rst),
    .push_i(of_adv), .push_rd_i(of_rd), .push_op_i(of_op), .push_lat_i(of_lat),
    .can_push_o(can_push), .pop_o(pop), .pop_rd_o(pop_rd), .pop_op_o(pop_op),
    .count_o(ex_cnt), .pend_v_o(pend_v), .pend_rd_o(pend_rd));

  assign occ_o[STG_IF] = if_v;
  assign occ_o[STG_ID] = id_v;
  assign occ_o[STG_OF] = of_v;
  assign occ_o[STG_EX] = (ex_cnt != '0);
  assign occ_o[STG_WO] = wo_v;
  assign ex_count_o    = ex_cnt;
  assign stall_o       = {of_v && !of_adv, id_v && !id_adv, if_v && !if_adv};
  assign hold_o        = hold;
  assign retire_o      = wo_v;
  assign retire_rd_o   = wo_q[REG_W-1:0];
  assign retire_op_o   = wo_q[WW-1:REG_W];

  // R1: reset leaves every step empty with no retire
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (occ_o == '0 && !retire_o));
  // R5: decode never passes an instruction whose producer sits in operand read
  p_no_early_read_r5: assert property (@(posedge clk) disable iff (rst)
    (id_adv && of_v && of_rd != '0) |-> (of_rd != id_rs1 && of_rd != id_rs2));
  // R9: a stalled decode also blocks fetch
  p_stall_chain_r9: assert property (@(posedge clk) disable iff (rst)
    (stall_o[1] && if_v) |-> stall_o[0]);
endmodule

// File: tb/pipe_interlock_tb_top.sv
`timescale 1ns/1ps
module pipe_interlock_tb_top;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_op = '0;
  logic [RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [4:0]    occ_o;
  logic [2:0]    ex_count_o;
  logic [2:0]    stall_o;
  logic          hold_o, retire_o;
  logic [RW-1:0] retire_rd_o;
  logic [1:0]    retire_op_o;

  int tests = 0, fails = 0, cyc = 0, t0 = 0, n_ret = 0;
  bit first = 1'b1;
  int log_cyc [32];
  int log_rd  [32];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pipe_interlock dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .occ_o(occ_o), .ex_count_o(ex_count_o), .stall_o(stall_o), .hold_o(hold_o),
    .retire_o(retire_o), .retire_rd_o(retire_rd_o), .retire_op_o(retire_op_o));

  always @(negedge clk) begin
    if (!rst && retire_o && n_ret < 32) begin
      log_cyc[n_ret] = cyc - t0 + 1;
      log_rd[n_ret]  = int'(retire_rd_o);
      n_ret++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; n_ret = 0; first = 1'b1;
  endtask

  task automatic send(int op, int rd, int rs1, int rs2);
    in_valid = 1'b1; in_op = 2'(op); in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2);
    while (!in_ready) @(negedge clk);
    if (first) begin t0 = cyc + 1; first = 1'b0; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rel(int n);
    while (cyc - t0 + 1 < n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "occupancy after reset", int'(occ_o), 0);
    chk("R1", "pool count after reset", int'(ex_count_o), 0);
    chk("R1", "ready after reset", int'(in_ready), 1);
    chk("R1", "retire after reset", int'(retire_o), 0);
    send(3, 3, 1, 2);
    wait_rel(5);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "occupancy after mid-run reset", int'(occ_o), 0);
    rst = 1'b0; n_ret = 0;
    repeat (12) @(negedge clk);
    chk("R1", "no retire of flushed divide", n_ret, 0);
  endtask

  task automatic t_latency(int op, int lat);
    do_reset();
    send(op, 7, 1, 2);
    wait_rel(16);
    chk("R4", "single retire count", n_ret, 1);
    chk("R3", "single retire cycle", log_cyc[0], 4 + lat);
    chk("R8", "single retire dest", log_rd[0], 7);
  endtask

  task automatic t_example();
    do_reset();
    send(2, 2, 10, 1);
    send(3, 5, 3, 4);
    send(0, 2, 5, 2);
    send(1, 5, 2, 6);
    wait_rel(5);
    chk("R9", "stall flags cycle 5", int'(stall_o), 3);
    chk("R5", "dependency hold cycle 5", int'(hold_o), 1);
    chk("R2", "ready low while fetch held", int'(in_ready), 0);
    chk("R9", "occupancy cycle 5", int'(occ_o), 5'b01011);
    chk("R7", "two in execute cycle 5", int'(ex_count_o), 2);
    wait_rel(20);
    chk("R11", "retire count", n_ret, 4);
    chk("R11", "multiply retire", log_cyc[0], 7);
    chk("R11", "divide retire", log_cyc[1], 11);
    chk("R11", "add retire", log_cyc[2], 13);
    chk("R11", "subtract retire", log_cyc[3], 15);
    chk("R8", "order of dests", log_rd[0]*1000 + log_rd[1]*100 + log_rd[2]*10 + log_rd[3], 2525);
  endtask

  task automatic t_reg0();
    do_reset();
    send(3, 0, 1, 2);
    send(0, 3, 0, 0);
    wait_rel(16);
    chk("R6", "add after divide to r0", log_cyc[1], 11);
  endtask

  task automatic t_overlap();
    do_reset();
    send(2, 1, 6, 7);
    send(3, 2, 6, 7);
    wait_rel(16);
    chk("R7", "multiply retire", log_cyc[0], 7);
    chk("R7", "overlapped divide retire", log_cyc[1], 11);
  endtask

  task automatic t_order();
    do_reset();
    send(3, 1, 6, 7);
    send(0, 2, 6, 7);
    wait_rel(16);
    chk("R8", "divide retire", log_cyc[0], 10);
    chk("R8", "younger add waits", log_cyc[1], 11);
    chk("R8", "younger dest", log_rd[1], 2);
  endtask

  task automatic t_rs2_dep();
    do_reset();
    send(2, 4, 9, 9);
    send(0, 5, 1, 4);
    wait_rel(14);
    chk("R5", "multiply retire", log_cyc[0], 7);
    chk("R5", "rs2 consumer retire", log_cyc[1], 9);
  endtask

  task automatic t_capacity();
    do_reset();
    send(3, 1, 9, 9);
    for (int k = 0; k < 4; k++) send(0, 10 + k, 9, 9);
    wait_rel(8);
    chk("R10", "operand read stalls when full", int'(stall_o[2]), 1);
    chk("R10", "pool full", int'(ex_count_o), 4);
    wait_rel(9);
    chk("R10", "operand read frees on pop", int'(stall_o[2]), 0);
    wait_rel(18);
    chk("R10", "retire count", n_ret, 5);
    chk("R10", "last add retire", log_cyc[4], 14);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency(0, 1);
    t_latency(1, 1);
    t_latency(2, 3);
    t_latency(3, 6);
    t_example();
    t_reg0();
    t_overlap();
    t_order();
    t_rs2_dep();
    t_capacity();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule